// File: doc/BRIEF.md
# Sequenced FIR Filter Instruction Unit

This block sits beside a processor datapath as a multi-cycle instruction extension that runs one step of a ten-tap integer FIR filter. The processor raises `start` together with an operation selector and two 32-bit operands. It then waits for the single-cycle `done` pulse and takes `result` in that same cycle. Three operations are defined. The first empties the sample history. The second overwrites one coefficient. The third pushes a new sample and returns one filtered output. Every other selector value completes as a harmless no-op.

The filtered output is built by a sequential multiply-accumulate that handles one tap per enabled clock. The wide sum is then shifted right arithmetically by 12 bits, which divides by 4096 and rounds toward negative infinity. Finally it is clamped to the signed 32-bit range. Because the tap count is fixed, a push always takes the same number of cycles, and the processor can rely on that bound. A low `clk_en` freezes the whole unit, and `reset` restores the default coefficient set and an empty history.

The controller has four named states. In IDLE, an enabled `start` is accepted. A push moves IDLE to MAC. Any other selector moves IDLE straight to DONE. MAC steps once per enabled cycle through taps 0 to 9, and on tap 9 it moves to SAT. SAT clamps and registers the output, then moves to DONE. DONE drives `done` for one enabled cycle and returns to IDLE.

Top module: `fir_ci_unit`

## Requirements
- R1: An enabled `start` is accepted only in IDLE. The operation it selects is performed by the unit, and completion is signalled solely by `done`.
- R2: The selector encodings are n=0 for clear history, n=1 for coefficient write, and n=2 for push. Every other value is a no-op. Clear, write and no-op all assert `done` in the cycle after `start` and return 0 on `result`.
- R3: A push asserts `done` exactly 12 enabled cycles after the cycle in which `start` was sampled. These are 10 tap cycles, one saturation cycle and one output cycle.
- R4: `done` is high for exactly one enabled cycle for each accepted operation.
- R5: While `clk_en` is low, no state changes. A push with N disabled cycles inside it completes after 12+N cycles and gives an unchanged value.
- R6: A `start` presented while an operation is in progress, including the cycle in which `done` is high, is ignored. It neither clears the history nor changes the result.
- R7: After reset, coefficients 0..9 are 0,0,16,64,127,127,64,16,0,0. An impulse of 1000 followed by nine zero pushes yields 0,0,3,15,31,31,15,3,0,0.
- R8: A push stores `dataa` as the newest sample x[0] and ages the older ones. The result is floor(sum over k of c[k]*x[k] / 4096), computed on signed values.
- R9: If the shifted sum exceeds the signed 32-bit range, `result` is clamped to 0x7FFFFFFF or 0x80000000.
- R10: A coefficient write puts `datab` into slot `dataa[3:0]`. An index of 10 or more changes nothing.
- R11: A clear zeroes all ten history samples and leaves the coefficients untouched.
- R12: After reset, `done` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clk_en | input | 1 | Clock enable; low freezes all state |
| reset | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation request, sampled in IDLE |
| n | input | 8 | Operation selector |
| dataa | input | 32 | Sample for push, slot index for write |
| datab | input | 32 | Coefficient value for write |
| result | output | 32 | Operation result, valid while `done` is high |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can land in the same cycle: a completion pulse and a fresh `start` that the processor issues too early. The bench provokes this by raising `start` with the clear selector during the DONE cycle of a push, and again in the middle of the MAC sweep. Each run is judged at the ports. The next push must still return the value that a history which was never cleared would give, and the interrupted push must keep its 12-cycle latency and its value. A second overlap is a stall inside the MAC sweep. There, the bench expects the latency to grow by exactly the number of disabled cycles and the sum to stay intact.

// File: rtl/fir_ci_pkg.sv
package fir_ci_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MAC,
        ST_SAT,
        ST_DONE
    } ci_state_t;

    localparam int OPC_CLEAR = 0;
    localparam int OPC_COEF  = 1;
    localparam int OPC_PUSH  = 2;

    // Reset values of the coefficient slots (symmetric low-pass shape).
    function automatic int default_coef(input int idx);
        case (idx)
            2, 7:    return 16;
            3, 6:    return 64;
            4, 5:    return 127;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/fir_ci_ctrl.sv
module fir_ci_ctrl
    import fir_ci_pkg::*;
#(
    parameter int TAPS  = 10,
    parameter int OP_W  = 8,
    parameter int IDX_W = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             clk_en,
    input  logic             reset,
    input  logic             start_i,
    input  logic [OP_W-1:0]  op_i,
    output logic             accept_o,
    output logic             clr_o,
    output logic             wr_o,
    output logic             push_o,
    output logic             mac_en_o,
    output logic             sat_en_o,
    output logic             done_o,
    output logic [IDX_W-1:0] tap_o
);

    localparam logic [IDX_W-1:0] LAST_TAP = IDX_W'(TAPS - 1);

    ci_state_t        state_q, state_d;
    logic [IDX_W-1:0] tap_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (op_i == OP_W'(OPC_PUSH)) state_d = ST_MAC;
                    else                         state_d = ST_DONE;
                end
            end
            ST_MAC:  if (tap_q == LAST_TAP) state_d = ST_SAT;
            ST_SAT:  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and tap counter
    always_ff @(posedge clk) begin
        if (reset) begin
            state_q <= ST_IDLE;
            tap_q   <= '0;
        end else if (clk_en) begin
            state_q <= state_d;
            if (state_q == ST_MAC) tap_q <= tap_q + 1'b1;
            else                   tap_q <= '0;
        end
    end

    // outputs
    always_comb begin
        accept_o = (state_q == ST_IDLE) && start_i && clk_en;
        clr_o    = accept_o && (op_i == OP_W'(OPC_CLEAR));
        wr_o     = accept_o && (op_i == OP_W'(OPC_COEF));
        push_o   = accept_o && (op_i == OP_W'(OPC_PUSH));
        mac_en_o = (state_q == ST_MAC) && clk_en;
        sat_en_o = (state_q == ST_SAT) && clk_en;
        done_o   = (state_q == ST_DONE);
        tap_o    = tap_q;
    end

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (reset)
        (done_o && clk_en) |=> !done_o);

    assert_sat_then_done_R3: assert property (@(posedge clk) disable iff (reset)
        (state_q == ST_SAT && clk_en) |=> done_o);

    assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (reset)
        (start_i && clk_en && state_q == ST_MAC && tap_q != LAST_TAP)
        |=> (state_q == ST_MAC && tap_q == $past(tap_q) + 1'b1));

    assert_hold_state_R5: assert property (@(posedge clk) disable iff (reset)
        !clk_en |=> ($stable(state_q) && $stable(tap_q)));

endmodule

// File: rtl/fir_ci_taps.sv
module fir_ci_taps
    import fir_ci_pkg::*;
#(
    parameter int TAPS   = 10,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 4,
    parameter int IDX_W  = $clog2(TAPS)
) (
    input  logic                     clk,
    input  logic                     clk_en,
    input  logic                     reset,
    input  logic                     clr_i,
    input  logic                     wr_i,
    input  logic                     push_i,
    input  logic [SEL_W-1:0]         wr_idx_i,
    input  logic signed [DATA_W-1:0] wr_val_i,
    input  logic signed [DATA_W-1:0] push_val_i,
    input  logic [IDX_W-1:0]         rd_idx_i,
    output logic signed [DATA_W-1:0] smp_o,
    output logic signed [DATA_W-1:0] cf_o
);

    logic signed [DATA_W-1:0] dl_q [TAPS];
    logic signed [DATA_W-1:0] cf_q [TAPS];

    for (genvar g = 0; g < TAPS; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (reset)                dl_q[g] <= '0;
                else if (clk_en && clr_i) dl_q[g] <= '0;
                else if (clk_en && push_i) dl_q[g] <= push_val_i;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (reset)                dl_q[g] <= '0;
                else if (clk_en && clr_i) dl_q[g] <= '0;
                else if (clk_en && push_i) dl_q[g] <= dl_q[g-1];
            end
        end

        always_ff @(posedge clk) begin
            if (reset)
                cf_q[g] <= DATA_W'(default_coef(g));
            else if (clk_en && wr_i && wr_idx_i == SEL_W'(g))
                cf_q[g] <= wr_val_i;
        end

        assert_hold_hist_R5: assert property (@(posedge clk) disable iff (reset)
            !clk_en |=> ($stable(dl_q[g]) && $stable(cf_q[g])));

        assert_clear_keeps_coef_R11: assert property (@(posedge clk) disable iff (reset)
            (clr_i && clk_en) |=> (dl_q[g] == '0 && $stable(cf_q[g])));
    end

    assign smp_o = dl_q[rd_idx_i];
    assign cf_o  = cf_q[rd_idx_i];

endmodule

// File: rtl/fir_ci_mac.sv
module fir_ci_mac #(
    parameter int DATA_W = 32,
    parameter int SHIFT  = 12,
    parameter int ACC_W  = 2 * DATA_W + 4
) (
    input  logic                     clk,
    input  logic                     clk_en,
    input  logic                     reset,
    input  logic                     accept_i,
    input  logic                     mac_en_i,
    input  logic                     sat_en_i,
    input  logic signed [DATA_W-1:0] smp_i,
    input  logic signed [DATA_W-1:0] cf_i,
    output logic [DATA_W-1:0]        res_o
);

    localparam logic signed [ACC_W-1:0] MAX_V =
        {{(ACC_W - DATA_W + 1){1'b0}}, {(DATA_W - 1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MIN_V =
        {{(ACC_W - DATA_W + 1){1'b1}}, {(DATA_W - 1){1'b0}}};

    logic signed [ACC_W-1:0]      acc_q;
    logic signed [2*DATA_W-1:0]   prod;
    logic signed [ACC_W-1:0]      shifted;
    logic [DATA_W-1:0]            clamped;

    assign prod    = smp_i * cf_i;
    assign shifted = acc_q >>> SHIFT;

    always_comb begin
        if (shifted > MAX_V)      clamped = MAX_V[DATA_W-1:0];
        else if (shifted < MIN_V) clamped = MIN_V[DATA_W-1:0];
        else                      clamped = shifted[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (reset) begin
            acc_q <= '0;
            res_o <= '0;
        end else if (clk_en) begin
            if (accept_i) begin
                acc_q <= '0;
                res_o <= '0;
            end else begin
                if (mac_en_i) acc_q <= acc_q + ACC_W'(prod);
                if (sat_en_i) res_o <= clamped;
            end
        end
    end

    assert_hold_acc_R5: assert property (@(posedge clk) disable iff (reset)
        !clk_en |=> ($stable(acc_q) && $stable(res_o)));

    assert_clear_on_accept_R8: assert property (@(posedge clk) disable iff (reset)
        accept_i |=> (acc_q == '0));

endmodule

// File: rtl/fir_ci_unit.sv
module fir_ci_unit
    import fir_ci_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OP_W   = 8,
    parameter int TAPS   = 10,
    parameter int SEL_W  = 4,
    parameter int SHIFT  = 12
) (
    input  logic              clk,
    input  logic              clk_en,
    input  logic              reset,
    input  logic              start,
    input  logic [OP_W-1:0]   n,
    input  logic [DATA_W-1:0] dataa,
    input  logic [DATA_W-1:0] datab,
    output logic [DATA_W-1:0] result,
    output logic              done
);

    localparam int IDX_W = $clog2(TAPS);

    logic             accept, clr, wr, push, mac_en, sat_en;
    logic [IDX_W-1:0] tap;
    logic signed [DATA_W-1:0] smp, cf;

    fir_ci_ctrl #(.TAPS(TAPS), .OP_W(OP_W), .IDX_W(IDX_W)) u_ctrl (
        .clk      (clk),
        .clk_en   (clk_en),
        .reset    (reset),
        .start_i  (start),
        .op_i     (n),
        .accept_o (accept),
        .clr_o    (clr),
        .wr_o     (wr),
        .push_o   (push),
        .mac_en_o (mac_en),
        .sat_en_o (sat_en),
        .done_o   (done),
        .tap_o    (tap)
    );

    fir_ci_taps #(.TAPS(TAPS), .DATA_W(DATA_W), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_taps (
        .clk        (clk),
        .clk_en     (clk_en),
        .reset      (reset),
        .clr_i      (clr),
        .wr_i       (wr),
        .push_i     (push),
        .wr_idx_i   (dataa[SEL_W-1:0]),
        .wr_val_i   (datab),
        .push_val_i (dataa),
        .rd_idx_i   (tap),
        .smp_o      (smp),
        .cf_o       (cf)
    );

    fir_ci_mac #(.DATA_W(DATA_W), .SHIFT(SHIFT)) u_mac (
        .clk      (clk),
        .clk_en   (clk_en),
        .reset    (reset),
        .accept_i (accept),
        .mac_en_i (mac_en),
        .sat_en_i (sat_en),
        .smp_i    (smp),
        .cf_i     (cf),
        .res_o    (result)
    );

    assert_short_op_R2: assert property (@(posedge clk) disable iff (reset)
        (accept && !push) |=> (done && result == '0));

    assert_accept_idle_R1: assert property (@(posedge clk) disable iff (reset)
        (done && clk_en) |-> !accept);

    assert_hold_port_R5: assert property (@(posedge clk) disable iff (reset)
        !clk_en |=> ($stable(result) && $stable(done)));

endmodule

// File: tb/fir_ci_unit_bench.sv
module fir_ci_unit_bench;

    logic        clk = 1'b0;
    logic        clk_en, reset, start, done;
    logic [7:0]  n;
    logic [31:0] dataa, datab, result;

    int errs = 0;
    int checks = 0;
    longint ref_dl [10];
    longint ref_cf [10];

    always #4 clk = ~clk;

    fir_ci_unit u_fir_ci_unit (
        .clk(clk), .clk_en(clk_en), .reset(reset), .start(start), .n(n),
        .dataa(dataa), .datab(datab), .result(result), .done(done)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint ref_push(input longint x);
        longint s;
        for (int k = 9; k > 0; k--) ref_dl[k] = ref_dl[k-1];
        ref_dl[0] = x;
        s = 0;
        for (int k = 0; k < 10; k++) s += ref_cf[k] * ref_dl[k];
        s = s >>> 12;
        if (s > 64'sd2147483647) s = 64'sd2147483647;
        if (s < -64'sd2147483648) s = -64'sd2147483648;
        return s;
    endfunction

    // One processor-style operation; optional stall and start injection.
    task automatic issue(input logic [7:0] op, input logic [31:0] a, input logic [31:0] b,
                         input int stall_at, input int stall_len, input int inject_at,
                         output logic [31:0] res, output int lat);
        @(negedge clk);
        n = op; dataa = a; datab = b; start = 1'b1;
        @(negedge clk);
        lat = 1;
        forever begin
            if (lat == inject_at) begin start = 1'b1; n = 8'd0; end
            else start = 1'b0;
            if (done || lat >= 100) break;
            if (lat == stall_at) begin
                clk_en = 1'b0;
                for (int s = 0; s < stall_len; s++) begin @(negedge clk); lat++; end
                clk_en = 1'b1;
            end
            @(negedge clk);
            lat++;
        end
        res = result;
        @(negedge clk);
        start = 1'b0;
        chk("R4 done low after pulse", longint'(done), 0);
    endtask

    task automatic push_chk(input longint x, input string tag, input int stall_at,
                            input int stall_len, input int inject_at);
        logic [31:0] r; int lat; longint e;
        issue(8'd2, 32'(x), 32'd0, stall_at, stall_len, inject_at, r, lat);
        e = ref_push(x);
        chk({tag, " value"}, longint'($signed(r)), e);
        chk({tag, " latency"}, lat, (stall_at > 0) ? 12 + stall_len : 12);
    endtask

    task automatic short_op(input logic [7:0] op, input logic [31:0] a,
                            input logic [31:0] b, input string tag);
        logic [31:0] r; int lat;
        issue(op, a, b, 0, 0, 0, r, lat);
        chk({tag, " latency"}, lat, 1);
        chk({tag, " result"}, longint'(r), 0);
        if (op == 8'd0) for (int k = 0; k < 10; k++) ref_dl[k] = 0;
        if (op == 8'd1 && a[3:0] < 4'd10) ref_cf[a[3:0]] = longint'($signed(b));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R12 done after reset", longint'(done), 0);
        chk("R12 result after reset", longint'(result), 0);
    endtask

    task automatic t_impulse;
        longint exp_seq [10] = '{0, 0, 3, 15, 31, 31, 15, 3, 0, 0};
        for (int i = 0; i < 10; i++) begin
            logic [31:0] r; int lat;
            issue(8'd2, (i == 0) ? 32'd1000 : 32'd0, 32'd0, 0, 0, 0, r, lat);
            void'(ref_push((i == 0) ? 1000 : 0));
            chk("R7 impulse response", longint'($signed(r)), exp_seq[i]);
            chk("R3 push latency", lat, 12);
        end
    endtask

    task automatic t_clear;
        push_chk(500, "R8 mixed", 0, 0, 0);
        push_chk(-700, "R8 mixed neg", 0, 0, 0);
        short_op(8'd0, 32'd0, 32'd0, "R11 clear");
        push_chk(0, "R11 history empty", 0, 0, 0);
        push_chk(4096, "R11 coef kept a", 0, 0, 0);
        push_chk(0, "R11 coef kept b", 0, 0, 0);
        push_chk(0, "R11 coef kept c", 0, 0, 0);
    endtask

    task automatic t_coef;
        short_op(8'd1, 32'd12, 32'd999, "R10 out-of-range write");
        push_chk(77, "R10 ignored index", 0, 0, 0);
        short_op(8'd1, 32'd0, 32'd4096, "R10 write slot0");
        short_op(8'd1, 32'd9, -32'sd8192, "R10 write slot9");
        push_chk(3, "R10 new coef", 0, 0, 0);
        short_op(8'd7, 32'd0, 32'd0, "R2 unused opcode");
        push_chk(5, "R2 unused left state", 0, 0, 0);
    endtask

    task automatic t_floor_sat;
        short_op(8'd1, 32'd0, 32'd1, "R8 coef one");
        short_op(8'd0, 32'd0, 32'd0, "R11 clear2");
        push_chk(-1, "R8 floor negative", 0, 0, 0);
        short_op(8'd0, 32'd0, 32'd0, "R11 clear3");
        short_op(8'd1, 32'd0, 32'h7FFFFFFF, "R9 big coef");
        push_chk(64'sd2147483647, "R9 clamp high", 0, 0, 0);
        push_chk(-64'sd2147483648, "R9 clamp low", 0, 0, 0);
    endtask

    task automatic t_stall_busy;
        short_op(8'd1, 32'd0, 32'd100, "R10 restore slot0");
        short_op(8'd0, 32'd0, 32'd0, "R11 clear4");
        push_chk(1234, "R5 stall in MAC", 4, 5, 0);
        push_chk(4321, "R6 start mid MAC", 0, 0, 5);
        push_chk(999, "R6 start on done", 0, 0, 12);
        push_chk(0, "R6 history kept", 0, 0, 0);
        push_chk(-50, "R1 plain push", 0, 0, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        ref_cf = '{0, 0, 16, 64, 127, 127, 64, 16, 0, 0};
        for (int k = 0; k < 10; k++) ref_dl[k] = 0;
        clk_en = 1'b1; reset = 1'b1; start = 1'b0; n = '0; dataa = '0; datab = '0;
        repeat (3) @(negedge clk);
        reset = 1'b0;
        t_reset();
        t_impulse();
        t_clear();
        t_coef();
        t_floor_sat();
        t_stall_busy();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule